// File: doc/BRIEF.md
# Circular Trace Capture Buffer

This block records a stream of trace frames into an on-chip ring memory. Frames arrive with a valid strobe and a one-cycle trigger pulse. While capture is enabled, each frame goes through a single formatting stage and is then written at the write pointer, which wraps at the end of the memory. A sticky wrap flag tells software where the oldest valid frame is. If the flag is set, the oldest frame is at the write pointer. If it is clear, the valid frames occupy addresses zero up to one below the write pointer.

Software loads a post-trigger frame count before it starts a run. Once a trigger is seen, every stored frame lowers that count. When the count is exhausted, acquisition completes and storing stops, even if enable stays set. Software then waits for the drained flag, rewinds or positions the read pointer, and pulls frames out through a data register that advances the pointer on each read.

The register bus is a plain select, write-strobe and read-strobe interface. Read data is combinational from the select lines.

Top module: `trace_ring_buf`

## Requirements
- R1: While capture is enabled, a frame presented with `frame_vld` high at clock edge N is written to memory at the current write pointer at edge N+1. The write pointer (select 3) then advances by one, modulo DEPTH.
- R2: Frames and trigger pulses presented while control bit 0 (enable) is clear are dropped. The write pointer and the status flags do not change.
- R3: Status bit 0 (wrap) sets when a frame is stored at address DEPTH-1. It stays set while capture keeps running.
- R4: Status bit 1 (triggered) sets when a trigger pulse is taken in during capture.
- R5: Every frame stored in the trigger's own cycle or later decrements the trigger counter (select 4). When the counter is zero after a trigger, status bit 2 (acquisition done) sets. No further frames are stored while enable remains 1.
- R6: Status bit 3 (drained) is low while a frame or trigger sits in the formatting stage, and high otherwise.
- R7: A control write that takes bit 0 from 0 to 1 clears status bits 0, 1 and 2. Clearing bit 0 leaves those bits unchanged.
- R8: The read pointer (select 2) is writable. A strobed read of the data register (select 5) returns the frame at the read pointer and advances the pointer by one, modulo DEPTH.
- R9: The write pointer and the trigger counter are writable and can be read back. The counter reads back its remaining value.
- R10: The control register (select 0) reads back bit 0 (enable) and bit 1 (demultiplexed port mode). Select 6 returns DEPTH and select 7 returns DATA_W. Reset leaves control, pointers and counter at zero and status at 0x8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_vld | input | 1 | Frame strobe |
| frame_data | input | DATA_W | Frame word |
| trig_in | input | 1 | Trigger pulse |
| reg_sel | input | 3 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effects only) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from `reg_sel` |

## Verification
The assertions assume that software does not write the write pointer or the trigger counter while frames are moving through the block. They also assume that a control write is never issued in the same cycle as a frame reaches the memory. The directed stimulus respects both conditions: it programs pointers and counts only while enable is clear or the formatting stage is empty, and it finishes each frame fully before it touches a register. Read strobes are issued only with the data select, and only after the stage has drained.

// File: rtl/trace_buf_pkg.sv
// Shared register selects and status bit positions for the trace ring buffer.
package trace_buf_pkg;
    typedef enum logic [2:0] {
        SEL_CTRL  = 3'd0,
        SEL_STAT  = 3'd1,
        SEL_RDPTR = 3'd2,
        SEL_WRPTR = 3'd3,
        SEL_TCNT  = 3'd4,
        SEL_DATA  = 3'd5,
        SEL_DEPTH = 3'd6,
        SEL_WIDTH = 3'd7
    } reg_sel_e;

    localparam int STAT_WRAP  = 0;
    localparam int STAT_TRIG  = 1;
    localparam int STAT_DONE  = 2;
    localparam int STAT_EMPTY = 3;
endpackage

// File: rtl/trb_ingress.sv
// Formatting stage: registers one incoming frame and trigger pulse.
// Assumes capturing is already qualified by enable and not-done.
module trb_ingress #(
    parameter int DATA_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capturing,
    input  logic              frame_vld,
    input  logic [DATA_W-1:0] frame_data,
    input  logic              trig_in,
    output logic              stg_vld,
    output logic              stg_trig,
    output logic [DATA_W-1:0] stg_data,
    output logic              drained
);
    // Stage valid and trigger flags, gated by capture state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_vld  <= 1'b0;
            stg_trig <= 1'b0;
        end else begin
            stg_vld  <= frame_vld & capturing;
            stg_trig <= trig_in & capturing;
        end
    end

    // Stage data, loaded only with a strobed frame
    always_ff @(posedge clk) begin
        if (!rst_n)         stg_data <= '0;
        else if (frame_vld) stg_data <= frame_data;
    end

    assign drained = ~stg_vld & ~stg_trig;

    // R2
    no_stage_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !capturing |=> !stg_vld && !stg_trig);
endmodule

// File: rtl/trb_ram.sv
// Inferred ring memory: one synchronous write port, one asynchronous read port.
module trb_ram #(
    parameter int DATA_W = 24,
    parameter int DEPTH  = 64,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [DEPTH];

    // Store a frame on write enable
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/trb_acq_ctrl.sv
// Acquisition control: write pointer, wrap, trigger and done flags,
// and post-trigger countdown. Assumes pointer/counter loads do not
// coincide with stored frames.
module trb_acq_ctrl #(
    parameter int DEPTH  = 64,
    parameter int ADDR_W = $clog2(DEPTH),
    parameter int CNT_W  = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture_en,
    input  logic              flag_clr,
    input  logic              stg_vld,
    input  logic              stg_trig,
    input  logic              wp_load,
    input  logic [ADDR_W-1:0] wp_wdata,
    input  logic              cnt_load,
    input  logic [CNT_W-1:0]  cnt_wdata,
    output logic              ram_we,
    output logic [ADDR_W-1:0] wr_ptr,
    output logic              full,
    output logic              triggered,
    output logic              acq_done,
    output logic [CNT_W-1:0]  trig_cnt
);
    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

    logic stage_ok, trig_eff, cnt_zero;
    assign stage_ok = capture_en & ~acq_done;
    assign trig_eff = triggered | (stg_trig & stage_ok);
    assign cnt_zero = (trig_cnt == '0);
    assign ram_we   = stg_vld & stage_ok & ~(trig_eff & cnt_zero);

    // Sticky status flags with clear on capture start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full      <= 1'b0;
            triggered <= 1'b0;
            acq_done  <= 1'b0;
        end else if (flag_clr) begin
            full      <= 1'b0;
            triggered <= 1'b0;
            acq_done  <= 1'b0;
        end else begin
            if (stg_trig && stage_ok)             triggered <= 1'b1;
            if (stage_ok && trig_eff && cnt_zero) acq_done  <= 1'b1;
            if (ram_we && wr_ptr == LAST)         full      <= 1'b1;
        end
    end

    // Write pointer: software load or wrapping advance
    always_ff @(posedge clk) begin
        if (!rst_n)       wr_ptr <= '0;
        else if (wp_load) wr_ptr <= wp_wdata;
        else if (ram_we)  wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
    end

    // Post-trigger countdown
    always_ff @(posedge clk) begin
        if (!rst_n)                  trig_cnt <= '0;
        else if (cnt_load)           trig_cnt <= cnt_wdata;
        else if (ram_we && trig_eff) trig_cnt <= trig_cnt - 1'b1;
    end

    // R1
    wp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we && !wp_load |=> wr_ptr == (($past(wr_ptr) == LAST) ? '0 : $past(wr_ptr) + 1'b1));
    // R5
    done_blocks_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acq_done |-> !ram_we);
    // R3
    wrap_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full && !flag_clr |=> full);
    // R7
    start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_clr |=> !full && !triggered && !acq_done);
endmodule

// File: rtl/trace_ring_buf.sv
// Top: register decode, control and read pointer, plus the ingress stage,
// acquisition control and ring memory. Read data is combinational.
module trace_ring_buf
    import trace_buf_pkg::*;
#(
    parameter int DATA_W = 24,
    parameter int DEPTH  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_vld,
    input  logic [DATA_W-1:0] frame_data,
    input  logic              trig_in,
    input  logic [2:0]        reg_sel,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata
);
    localparam int ADDR_W = $clog2(DEPTH);
    localparam int CNT_W  = ADDR_W + 1;
    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

    reg_sel_e sel;
    assign sel = reg_sel_e'(reg_sel);

    logic              ctl_en, ctl_demux;
    logic [ADDR_W-1:0] rd_ptr, wr_ptr;
    logic              stg_vld, stg_trig, drained, ram_we;
    logic [DATA_W-1:0] stg_data, ram_q;
    logic              full, triggered, acq_done;
    logic [CNT_W-1:0]  trig_cnt;
    logic              ctl_wr, en_rise, rp_wr, data_rd;

    assign ctl_wr  = reg_wr && sel == SEL_CTRL;
    assign en_rise = ctl_wr && reg_wdata[0] && !ctl_en;
    assign rp_wr   = reg_wr && sel == SEL_RDPTR;
    assign data_rd = reg_rd && sel == SEL_DATA;

    // Control register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_en    <= 1'b0;
            ctl_demux <= 1'b0;
        end else if (ctl_wr) begin
            ctl_en    <= reg_wdata[0];
            ctl_demux <= reg_wdata[1];
        end
    end

    // Read pointer: software load or advance on data read
    always_ff @(posedge clk) begin
        if (!rst_n)       rd_ptr <= '0;
        else if (rp_wr)   rd_ptr <= reg_wdata[ADDR_W-1:0];
        else if (data_rd) rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
    end

    trb_ingress #(.DATA_W(DATA_W)) ingress_i (
        .clk(clk), .rst_n(rst_n), .capturing(ctl_en & ~acq_done),
        .frame_vld(frame_vld), .frame_data(frame_data), .trig_in(trig_in),
        .stg_vld(stg_vld), .stg_trig(stg_trig), .stg_data(stg_data),
        .drained(drained)
    );

    trb_acq_ctrl #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) acq_i (
        .clk(clk), .rst_n(rst_n), .capture_en(ctl_en), .flag_clr(en_rise),
        .stg_vld(stg_vld), .stg_trig(stg_trig),
        .wp_load(reg_wr && sel == SEL_WRPTR), .wp_wdata(reg_wdata[ADDR_W-1:0]),
        .cnt_load(reg_wr && sel == SEL_TCNT), .cnt_wdata(reg_wdata[CNT_W-1:0]),
        .ram_we(ram_we), .wr_ptr(wr_ptr), .full(full), .triggered(triggered),
        .acq_done(acq_done), .trig_cnt(trig_cnt)
    );

    trb_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) ram_i (
        .clk(clk), .we(ram_we), .waddr(wr_ptr), .wdata(stg_data),
        .raddr(rd_ptr), .rdata(ram_q)
    );

    // Register read multiplexer
    always_comb begin
        reg_rdata = '0;
        case (sel)
            SEL_CTRL:  reg_rdata = {30'd0, ctl_demux, ctl_en};
            SEL_STAT: begin
                reg_rdata[STAT_WRAP]  = full;
                reg_rdata[STAT_TRIG]  = triggered;
                reg_rdata[STAT_DONE]  = acq_done;
                reg_rdata[STAT_EMPTY] = drained;
            end
            SEL_RDPTR: reg_rdata = 32'(rd_ptr);
            SEL_WRPTR: reg_rdata = 32'(wr_ptr);
            SEL_TCNT:  reg_rdata = 32'(trig_cnt);
            SEL_DATA:  reg_rdata = 32'(ram_q);
            SEL_DEPTH: reg_rdata = 32'(DEPTH);
            SEL_WIDTH: reg_rdata = 32'(DATA_W);
            default:   reg_rdata = '0;
        endcase
    end

    // R8
    rdptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_rd && !rp_wr |=> rd_ptr == (($past(rd_ptr) == LAST) ? '0 : $past(rd_ptr) + 1'b1));
    // R6
    drained_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_vld && ctl_en && !acq_done |=> !drained);
endmodule

// File: tb/trace_ring_buf_tb_top.sv
module trace_ring_buf_tb_top;
    localparam int DW = 24;
    localparam int DP = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          frame_vld = 1'b0;
    logic [DW-1:0] frame_data = '0;
    logic          trig_in = 1'b0;
    logic [2:0]    reg_sel = '0;
    logic          reg_wr = 1'b0;
    logic          reg_rd = 1'b0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    trace_ring_buf #(.DATA_W(DW), .DEPTH(DP)) dut_i (
        .clk(clk), .rst_n(rst_n), .frame_vld(frame_vld), .frame_data(frame_data),
        .trig_in(trig_in), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic wr_reg(input logic [2:0] s, input logic [31:0] d);
        @(negedge clk);
        reg_sel = s; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [2:0] s, output logic [31:0] d);
        @(negedge clk);
        reg_sel = s;
        #1 d = reg_rdata;
    endtask

    // Sample the data register, then strobe it to advance the read pointer
    task automatic pop(output logic [31:0] d);
        @(negedge clk);
        reg_sel = 3'd5;
        #1 d = reg_rdata;
        reg_rd = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic send(input logic [DW-1:0] d, input logic t);
        @(negedge clk);
        frame_vld = 1'b1; frame_data = d; trig_in = t;
        @(negedge clk);
        frame_vld = 1'b0; trig_in = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd_reg(3'd0, v); check("R10 ctrl reset", v, 32'h0);
        rd_reg(3'd1, v); check("R10 status reset", v, 32'h8);
        rd_reg(3'd3, v); check("R10 wrptr reset", v, 32'h0);
        rd_reg(3'd6, v); check("R10 depth", v, 32'(DP));
        rd_reg(3'd7, v); check("R10 width", v, 32'(DW));
    endtask

    task automatic t_basic;
        logic [31:0] v;
        wr_reg(3'd0, 32'h1);
        @(negedge clk);
        frame_vld = 1'b1; frame_data = 24'h000111;
        @(posedge clk); #1;
        frame_vld = 1'b0;
        reg_sel = 3'd1; #0 check("R6 drained low", 32'(reg_rdata[3]), 32'h0);
        @(posedge clk); #1;
        check("R6 drained high", 32'(reg_rdata[3]), 32'h1);
        send(24'h000222, 1'b0);
        rd_reg(3'd3, v); check("R1 wrptr after two", v, 32'h2);
        wr_reg(3'd2, 32'h0);
        pop(v); check("R1 R8 frame0", v, 32'h111);
        pop(v); check("R1 R8 frame1", v, 32'h222);
        rd_reg(3'd2, v); check("R8 rdptr advanced", v, 32'h2);
    endtask

    task automatic t_disabled;
        logic [31:0] v;
        wr_reg(3'd0, 32'h0);
        send(24'h000333, 1'b1);
        rd_reg(3'd3, v); check("R2 wrptr unchanged", v, 32'h2);
        rd_reg(3'd1, v); check("R2 status unchanged", v, 32'h8);
    endtask

    task automatic t_countdown;
        logic [31:0] v;
        wr_reg(3'd3, 32'h0);
        wr_reg(3'd4, 32'h3);
        rd_reg(3'd4, v); check("R9 tcnt readback", v, 32'h3);
        wr_reg(3'd0, 32'h1);
        send(24'h0000A0, 1'b0);
        send(24'h0000A1, 1'b0);
        rd_reg(3'd1, v); check("R4 no trigger yet", v, 32'h8);
        rd_reg(3'd4, v); check("R5 tcnt idle", v, 32'h3);
        send(24'h0000A2, 1'b1);
        rd_reg(3'd1, v); check("R4 triggered", v, 32'hA);
        rd_reg(3'd4, v); check("R5 tcnt after trig frame", v, 32'h2);
        send(24'h0000A3, 1'b0);
        send(24'h0000A4, 1'b0);
        rd_reg(3'd1, v); check("R5 done set", v, 32'hE);
        rd_reg(3'd4, v); check("R5 tcnt zero", v, 32'h0);
        send(24'h0000A5, 1'b0);
        rd_reg(3'd3, v); check("R5 no store after done", v, 32'h5);
        wr_reg(3'd2, 32'h4);
        pop(v); check("R5 last frame", v, 32'hA4);
        wr_reg(3'd0, 32'h3);
        rd_reg(3'd0, v); check("R10 ctrl mode bit", v, 32'h3);
        rd_reg(3'd1, v); check("R7 no clear without rise", v, 32'hE);
        wr_reg(3'd0, 32'h0);
        rd_reg(3'd1, v); check("R7 disable keeps flags", v, 32'hE);
    endtask

    task automatic t_wrap;
        logic [31:0] v;
        wr_reg(3'd3, 32'h0);
        wr_reg(3'd4, 32'h0);
        wr_reg(3'd0, 32'h1);
        rd_reg(3'd1, v); check("R7 start clears flags", v, 32'h8);
        for (int i = 0; i < DP; i++) send(24'(32'h1000 + i), 1'b0);
        rd_reg(3'd1, v); check("R3 wrap set", v, 32'h9);
        rd_reg(3'd3, v); check("R3 wrptr wrapped", v, 32'h0);
        send(24'h002000, 1'b0);
        rd_reg(3'd1, v); check("R3 wrap sticky", v, 32'h9);
        rd_reg(3'd3, v); check("R1 wrptr one", v, 32'h1);
        wr_reg(3'd2, 32'(DP - 1));
        pop(v); check("R8 top entry", v, 32'(32'h1000 + DP - 1));
        pop(v); check("R8 wrapped entry", v, 32'h2000);
        rd_reg(3'd2, v); check("R8 rdptr wrapped", v, 32'h1);
        wr_reg(3'd0, 32'h0);
        rd_reg(3'd1, v); check("R7 stop keeps wrap", v, 32'h9);
        wr_reg(3'd0, 32'h1);
        rd_reg(3'd1, v); check("R7 restart clears wrap", v, 32'h8);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got 0x0 expected 0x1");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_basic;
        t_disabled;
        t_countdown;
        t_wrap;
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule